// File: doc/BRIEF.md
# Floating Point Add/Subtract Alignment Stage

This block is the front half of a single precision adder. It takes two 32-bit IEEE-754 words, an add/subtract opcode and a rounding mode. In one registered cycle it produces everything a normalize-and-round stage needs. It decides whether the operation is a true addition or a true subtraction, and it orders the operands so that the larger magnitude always comes first. It shifts the smaller significand right to line up the binary points and keeps every bit that falls off the end. It then adds or subtracts the two significands.

The outputs are an unnormalized 28-bit sum, the exponent of the larger operand, the result sign, the effective-operation bit and three special-value flags. The sum holds a carry bit, 24 significand bits and three low bits for guard, round and sticky. A downstream stage must find the leading one, adjust the exponent and round. The rounding mode is used here only to sign an exact zero.

Top module: `fpa_align_top`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared to zero on that edge.
- R2: Outputs change only at the rising clock edge and reflect the inputs present at the previous edge, a latency of one cycle.
- R3: `eff_sub_o` is 1 (true subtraction) exactly when `op_a[31] ^ op_b[31] ^ sub_op` is 1. `sub_op` = 0 selects add and 1 selects subtract.
- R4: The operand with the larger bits [30:0] is the "large" operand, and operand A wins a tie. `exp_o` is its effective exponent: bits [30:23], with a stored 0 read as 1. A true subtraction never yields a carry/borrow bit (`sum_o[27]` = 0).
- R5: The significand of the small operand is its 23 fraction bits with a hidden bit of 1 when its exponent is nonzero. Three zero bits are appended to it. It is then shifted right by the difference of the effective exponents. Bit 0 of the result is ORed with every bit shifted out. From a difference of 27 upward the value is 0 except bit 0, which is 1 when the significand is nonzero.
- R6: `sum_o` is the large operand's significand with three zero bits appended, plus or minus the aligned small value, as a 28-bit unsigned result.
- R7: `sign_o` is the sign of the large operand, with B's sign inverted when `sub_op` is 1. The exception is a true subtraction whose `sum_o` is 0: the sign is then 0, or 1 when `rnd_mode` is 2'b11 (toward minus infinity). The other modes are 2'b00 nearest-even, 2'b01 toward zero and 2'b10 toward plus infinity.
- R8: `snan_o` is 1 when either operand has exponent 8'hFF, a nonzero fraction and fraction bit 22 equal to 0.
- R9: `qnan_o` is 1 when either operand is a NaN (exponent 8'hFF, nonzero fraction), or when both operands are infinities and the operation is a true subtraction. `inf_o` is 1 when either operand is an infinity and `qnan_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | Operand A, IEEE-754 single |
| op_b | input | 32 | Operand B, IEEE-754 single |
| sub_op | input | 1 | 0 add, 1 subtract |
| rnd_mode | input | 2 | Rounding mode, used for the sign of an exact zero |
| sum_o | output | 28 | Carry, 24 significand bits, guard, round, sticky |
| exp_o | output | 8 | Effective exponent of the larger operand |
| sign_o | output | 1 | Result sign |
| eff_sub_o | output | 1 | 1 when a true subtraction was performed |
| snan_o | output | 1 | Signaling NaN seen on an input |
| qnan_o | output | 1 | Result is a quiet NaN |
| inf_o | output | 1 | Result is an infinity |

## Verification
Swapping and sticky collection meet in the same cycle whenever the smaller operand arrives on port A with an exponent gap large enough to push its bits past the guard and round positions. The bench provokes this with random B exponents a few steps above A, and with directed gaps of 26 and 30. It judges the case by comparing the 28-bit sum against a bench model built from the requirements. A second collision is true subtraction of equal magnitudes: the swap tie rule and the zero-sign rule act together. Each rounding mode is applied to that case and the sign is checked.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int FP_EXP_W = 8;
  localparam int FP_MAN_W = 23;
  localparam int FP_GRS_W = 3;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_UP      = 2'b10,
    RM_DOWN    = 2'b11
  } rmode_e;
endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int WORD_W = EXP_W + MAN_W + 1
) (
  input  logic [WORD_W-1:0]      word_i,
  output logic                   sign_o,
  output logic [EXP_W-1:0]       eexp_o,
  output logic [MAN_W:0]         sig_o,
  output logic [EXP_W+MAN_W-1:0] mag_o,
  output logic                   nan_o,
  output logic                   snan_o,
  output logic                   inf_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] frac_f;
  logic             hidden;
  logic             exp_max;

  always_comb begin
    exp_f   = word_i[EXP_W+MAN_W-1:MAN_W];
    frac_f  = word_i[MAN_W-1:0];
    hidden  = |exp_f;
    exp_max = &exp_f;
    sign_o  = word_i[WORD_W-1];
    // subnormals share the scale of the smallest normal exponent
    eexp_o  = hidden ? exp_f : EXP_W'(1);
    sig_o   = {hidden, frac_f};
    mag_o   = word_i[EXP_W+MAN_W-1:0];
    nan_o   = exp_max & (|frac_f);
    snan_o  = exp_max & (|frac_f) & ~frac_f[MAN_W-1];
    inf_o   = exp_max & ~(|frac_f);
  end
endmodule

// File: rtl/fpa_swap_align.sv
module fpa_swap_align #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int GRS_W = 3,
  localparam int SIG_W = MAN_W + 1,
  localparam int EXT_W = SIG_W + GRS_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [EXP_W+MAN_W-1:0] mag_a_i,
  input  logic [EXP_W+MAN_W-1:0] mag_b_i,
  input  logic [EXP_W-1:0]       eexp_a_i,
  input  logic [EXP_W-1:0]       eexp_b_i,
  input  logic [SIG_W-1:0]       sig_a_i,
  input  logic [SIG_W-1:0]       sig_b_i,
  input  logic                   sgn_a_i,
  input  logic                   sgn_b_i,
  output logic [EXT_W-1:0]       big_ext_o,
  output logic [EXT_W-1:0]       small_al_o,
  output logic [EXP_W-1:0]       exp_big_o,
  output logic                   sign_big_o
);
  logic             b_wins;
  logic [EXP_W-1:0] exp_small;
  logic [EXP_W-1:0] shift_amt;
  logic [SIG_W-1:0] sig_big;
  logic [SIG_W-1:0] sig_small;
  logic [EXT_W-1:0] small_ext;
  logic [EXT_W-1:0] shifted;
  logic             lost;

  // magnitude ordering: exponent field first, then fraction; A keeps ties
  always_comb begin
    b_wins     = mag_b_i > mag_a_i;
    exp_big_o  = b_wins ? eexp_b_i : eexp_a_i;
    exp_small  = b_wins ? eexp_a_i : eexp_b_i;
    sig_big    = b_wins ? sig_b_i  : sig_a_i;
    sig_small  = b_wins ? sig_a_i  : sig_b_i;
    sign_big_o = b_wins ? sgn_b_i  : sgn_a_i;
    shift_amt  = exp_big_o - exp_small;
  end

  always_comb begin
    small_ext = {sig_small, {GRS_W{1'b0}}};
    big_ext_o = {sig_big, {GRS_W{1'b0}}};
    shifted   = small_ext >> shift_amt;
    lost      = 1'b0;
    for (int i = 0; i < EXT_W; i++) begin
      if (EXP_W'(i) < shift_amt) lost = lost | small_ext[i];
    end
    small_al_o = {shifted[EXT_W-1:1], shifted[0] | lost};
  end

  a_r5_no_shift_keeps_value: assert property (@(posedge clk) disable iff (rst)
    (exp_big_o == exp_small) |-> (small_al_o == {sig_small, {GRS_W{1'b0}}}));

  a_r5_far_is_sticky_only: assert property (@(posedge clk) disable iff (rst)
    (shift_amt >= EXP_W'(EXT_W)) |-> ((small_al_o[EXT_W-1:1] == '0) && (small_al_o[0] == |sig_small)));

  a_r4_big_exp_dominates: assert property (@(posedge clk) disable iff (rst)
    exp_big_o >= exp_small);
endmodule

// File: rtl/fpa_addsub.sv
module fpa_addsub #(
  parameter int EXT_W = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EXT_W-1:0] big_i,
  input  logic [EXT_W-1:0] small_i,
  input  logic             eff_sub_i,
  input  logic             sign_big_i,
  input  logic             zero_neg_i,
  output logic [EXT_W:0]   sum_o,
  output logic             sign_o
);
  logic [EXT_W:0] add_v;
  logic [EXT_W:0] sub_v;

  always_comb begin
    add_v  = {1'b0, big_i} + {1'b0, small_i};
    sub_v  = {1'b0, big_i} - {1'b0, small_i};
    sum_o  = eff_sub_i ? sub_v : add_v;
    // exact cancellation is signed by the rounding direction
    sign_o = (eff_sub_i && (sub_v == '0)) ? zero_neg_i : sign_big_i;
  end

  a_r4_no_borrow: assert property (@(posedge clk) disable iff (rst)
    eff_sub_i |-> !sum_o[EXT_W]);

  a_r6_add_not_below_big: assert property (@(posedge clk) disable iff (rst)
    !eff_sub_i |-> (sum_o >= {1'b0, big_i}));
endmodule

// File: rtl/fpa_align_top.sv
module fpa_align_top
  import fpa_pkg::*;
#(
  parameter int EXP_W = FP_EXP_W,
  parameter int MAN_W = FP_MAN_W,
  parameter int GRS_W = FP_GRS_W,
  localparam int WORD_W = EXP_W + MAN_W + 1,
  localparam int MAG_W  = EXP_W + MAN_W,
  localparam int SIG_W  = MAN_W + 1,
  localparam int EXT_W  = SIG_W + GRS_W,
  localparam int SUM_W  = EXT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              sub_op,
  input  logic [1:0]        rnd_mode,
  output logic [SUM_W-1:0]  sum_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic              sign_o,
  output logic              eff_sub_o,
  output logic              snan_o,
  output logic              qnan_o,
  output logic              inf_o
);
  logic [WORD_W-1:0] opnd    [2];
  logic              sgn     [2];
  logic [EXP_W-1:0]  eexp    [2];
  logic [SIG_W-1:0]  sig     [2];
  logic [MAG_W-1:0]  mag     [2];
  logic              is_nan  [2];
  logic              is_snan [2];
  logic              is_inf  [2];

  assign opnd[0] = op_a;
  assign opnd[1] = op_b;

  for (genvar k = 0; k < 2; k++) begin : g_unpack
    fpa_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
      .word_i (opnd[k]),
      .sign_o (sgn[k]),
      .eexp_o (eexp[k]),
      .sig_o  (sig[k]),
      .mag_o  (mag[k]),
      .nan_o  (is_nan[k]),
      .snan_o (is_snan[k]),
      .inf_o  (is_inf[k])
    );
  end

  logic             sgn_b_eff;
  logic             eff_sub;
  logic             zero_neg;
  logic [EXT_W-1:0] big_ext;
  logic [EXT_W-1:0] small_al;
  logic [EXP_W-1:0] exp_big;
  logic             sign_big;
  logic [SUM_W-1:0] sum_c;
  logic             sign_c;
  logic             qnan_c;
  logic             inf_c;

  always_comb begin
    sgn_b_eff = sgn[1] ^ sub_op;
    eff_sub   = sgn[0] ^ sgn_b_eff;
    zero_neg  = rmode_e'(rnd_mode) == RM_DOWN;
    qnan_c    = is_nan[0] | is_nan[1] | (is_inf[0] & is_inf[1] & eff_sub);
    inf_c     = (is_inf[0] | is_inf[1]) & ~qnan_c;
  end

  fpa_swap_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GRS_W(GRS_W)) u_align (
    .clk        (clk),
    .rst        (rst),
    .mag_a_i    (mag[0]),
    .mag_b_i    (mag[1]),
    .eexp_a_i   (eexp[0]),
    .eexp_b_i   (eexp[1]),
    .sig_a_i    (sig[0]),
    .sig_b_i    (sig[1]),
    .sgn_a_i    (sgn[0]),
    .sgn_b_i    (sgn_b_eff),
    .big_ext_o  (big_ext),
    .small_al_o (small_al),
    .exp_big_o  (exp_big),
    .sign_big_o (sign_big)
  );

  fpa_addsub #(.EXT_W(EXT_W)) u_addsub (
    .clk        (clk),
    .rst        (rst),
    .big_i      (big_ext),
    .small_i    (small_al),
    .eff_sub_i  (eff_sub),
    .sign_big_i (sign_big),
    .zero_neg_i (zero_neg),
    .sum_o      (sum_c),
    .sign_o     (sign_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o     <= '0;
      exp_o     <= '0;
      sign_o    <= 1'b0;
      eff_sub_o <= 1'b0;
      snan_o    <= 1'b0;
      qnan_o    <= 1'b0;
      inf_o     <= 1'b0;
    end else begin
      sum_o     <= sum_c;
      exp_o     <= exp_big;
      sign_o    <= sign_c;
      eff_sub_o <= eff_sub;
      snan_o    <= is_snan[0] | is_snan[1];
      qnan_o    <= qnan_c;
      inf_o     <= inf_c;
    end
  end

  // marks that the output registers hold a computed value, not a reset value
  logic primed_q;
  always_ff @(posedge clk) begin
    if (rst) primed_q <= 1'b0;
    else     primed_q <= 1'b1;
  end

  a_r9_inf_nan_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(inf_o && qnan_o));

  a_r3_effective_op: assert property (@(posedge clk) disable iff (rst)
    primed_q |-> (eff_sub_o == ($past(op_a[WORD_W-1]) ^ $past(op_b[WORD_W-1]) ^ $past(sub_op))));

  a_r7_zero_positive: assert property (@(posedge clk) disable iff (rst)
    (primed_q && eff_sub_o && (sum_o == '0) && ($past(rnd_mode) != 2'b11)) |-> !sign_o);

  a_r8_snan_is_nan: assert property (@(posedge clk) disable iff (rst)
    snan_o |-> qnan_o);
endmodule

// File: tb/tb_fpa_align_top.sv
`timescale 1ns/1ps
module tb_fpa_align_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        sub_op = 1'b0;
  logic [1:0]  rnd_mode = 2'b00;
  logic [27:0] sum_o;
  logic [7:0]  exp_o;
  logic        sign_o, eff_sub_o, snan_o, qnan_o, inf_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fpa_align_top dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .sub_op(sub_op),
    .rnd_mode(rnd_mode), .sum_o(sum_o), .exp_o(exp_o), .sign_o(sign_o),
    .eff_sub_o(eff_sub_o), .snan_o(snan_o), .qnan_o(qnan_o), .inf_o(inf_o)
  );

  typedef struct packed {
    logic [27:0] sum;
    logic [7:0]  ex;
    logic        sg;
    logic        es;
    logic        sn;
    logic        qn;
    logic        inf;
  } res_t;

  function automatic res_t model(logic [31:0] a, logic [31:0] b, logic s, logic [1:0] rm);
    res_t r;
    logic sa, sb, bl, sl;
    logic [7:0] ea, eb, el, esm;
    logic [23:0] ga, gb, gl, gs;
    logic [63:0] fs, al, lx, sm;
    int d;
    sa = a[31]; sb = b[31] ^ s;
    ea = (a[30:23] == 8'd0) ? 8'd1 : a[30:23];
    eb = (b[30:23] == 8'd0) ? 8'd1 : b[30:23];
    ga = {a[30:23] != 8'd0, a[22:0]};
    gb = {b[30:23] != 8'd0, b[22:0]};
    bl = b[30:0] > a[30:0];
    el = bl ? eb : ea;  esm = bl ? ea : eb;
    gl = bl ? gb : ga;  gs = bl ? ga : gb;
    sl = bl ? sb : sa;
    d = int'(el) - int'(esm);
    fs = {37'd0, gs, 3'b000};
    if (d >= 27) al = {63'd0, gs != 24'd0};
    else begin
      al = fs >> d;
      if ((fs & ((64'd1 << d) - 64'd1)) != 64'd0) al[0] = 1'b1;
    end
    lx = {37'd0, gl, 3'b000};
    r.es = sa ^ sb;
    sm = r.es ? lx - al : lx + al;
    r.sum = sm[27:0];
    r.ex = el;
    r.sg = (r.es && sm == 64'd0) ? (rm == 2'b11) : sl;
    r.sn = (a[30:23] == 8'hFF && a[22:0] != 0 && !a[22]) ||
           (b[30:23] == 8'hFF && b[22:0] != 0 && !b[22]);
    r.qn = (a[30:23] == 8'hFF && a[22:0] != 0) || (b[30:23] == 8'hFF && b[22:0] != 0) ||
           (a[30:0] == 31'h7F800000 && b[30:0] == 31'h7F800000 && r.es);
    r.inf = !r.qn && (a[30:0] == 31'h7F800000 || b[30:0] == 31'h7F800000);
    return r;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // drive at a falling edge, the design registers at the rising edge,
  // compare at the following falling edge
  task automatic run_vec(logic [31:0] a, logic [31:0] b, logic s, logic [1:0] rm);
    res_t e;
    op_a = a; op_b = b; sub_op = s; rnd_mode = rm;
    e = model(a, b, s, rm);
    @(negedge clk);
    chk("R2,R5,R6", "sum", {4'd0, sum_o}, {4'd0, e.sum});
    chk("R4", "exp", {24'd0, exp_o}, {24'd0, e.ex});
    chk("R7", "sign", {31'd0, sign_o}, {31'd0, e.sg});
    chk("R3", "eff_sub", {31'd0, eff_sub_o}, {31'd0, e.es});
    chk("R8", "snan", {31'd0, snan_o}, {31'd0, e.sn});
    chk("R9", "qnan", {31'd0, qnan_o}, {31'd0, e.qn});
    chk("R9", "inf", {31'd0, inf_o}, {31'd0, e.inf});
    if (e.es) chk("R4", "no borrow", {31'd0, sum_o[27]}, 32'd0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #4000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    op_a = 32'h3F800000; op_b = 32'h40000000; sub_op = 1'b1; rnd_mode = 2'b11;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held with live inputs
    chk("R1", "reset sum", {4'd0, sum_o}, 32'd0);
    chk("R1", "reset flags", {25'd0, exp_o, sign_o, eff_sub_o, snan_o, qnan_o, inf_o} , 32'd0);
    rst = 1'b0;

    // R6: 1.0 + 1.0 gives a carry into bit 27
    run_vec(32'h3F800000, 32'h3F800000, 1'b0, 2'b00);
    chk("R6", "1+1 hand value", {4'd0, sum_o}, 32'h08000000);
    // R7: exact cancellation, every rounding mode
    for (int m = 0; m < 4; m++) begin
      run_vec(32'h3F800000, 32'h3F800000, 1'b1, 2'(m));
      chk("R7", "zero sign by mode", {31'd0, sign_o}, (m == 3) ? 32'd1 : 32'd0);
    end
    // R4: smaller operand on A, swap keeps the result non-negative
    run_vec(32'h3F800000, 32'h40400000, 1'b1, 2'b00);
    chk("R7", "swapped sign", {31'd0, sign_o}, 32'd1);
    // R5: gap of 30 leaves only the sticky bit
    run_vec(32'h3F800000, 32'h4E800000, 1'b0, 2'b00);
    chk("R5", "gap 30 hand value", {4'd0, sum_o}, 32'h04000001);
    run_vec(32'h3F800001, 32'h4C800000, 1'b1, 2'b01);
    run_vec(32'h00000001, 32'h00000003, 1'b0, 2'b00);
    // R9: infinity cases
    run_vec(32'h7F800000, 32'h7F800000, 1'b1, 2'b00);
    chk("R9", "inf-inf quiet NaN", {31'd0, qnan_o}, 32'd1);
    run_vec(32'h7F800000, 32'hFF800000, 1'b1, 2'b00);
    chk("R9", "inf+inf stays inf", {31'd0, inf_o}, 32'd1);
    run_vec(32'h3F800000, 32'hFF800000, 1'b0, 2'b10);
    // R8: signaling and quiet NaN inputs
    run_vec(32'h7F800001, 32'h3F800000, 1'b0, 2'b00);
    chk("R8", "snan on A", {31'd0, snan_o}, 32'd1);
    run_vec(32'h3F800000, 32'h7FC00000, 1'b0, 2'b00);
    chk("R8", "quiet NaN is not signaling", {31'd0, snan_o}, 32'd0);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      logic [7:0] eb;
      a = $urandom;
      b = $urandom;
      case ($urandom % 6)
        0, 1: begin eb = a[30:23] + 8'($urandom % 4); b[30:23] = eb; end
        2: begin eb = a[30:23] + 8'(24 + $urandom % 6); b[30:23] = eb; end
        3: b[30:0] = a[30:0];
        4: b[30:23] = ($urandom % 2) ? 8'hFF : 8'h00;
        default: ;
      endcase
      run_vec(a, b, 1'($urandom), 2'($urandom));
    end
    finish_run();
  end
endmodule